// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of five interrupt requests the core should service next. The core strobes a query at every instruction boundary. One cycle later the controller answers with a take-interrupt pulse, a 16-bit service address and a flag that marks the non-vectored source. The non-vectored source is also answered with a one-cycle active-low acknowledge, so external logic can place an instruction on the bus.

The five sources have a fixed rank. The non-maskable source is first. Next come three maskable vectored sources (high, middle, low). The general maskable non-vectored request is last. The non-maskable source bypasses the global enable and the mask bits. It is edge detected, and it must still be high when the query arrives. The high vectored source is captured on a rising edge and held until it is serviced. The middle and low sources are level sensitive. Single-cycle enable and disable pulses control the global enable, and a mask-write strobe loads three per-source mask bits. Accepting any interrupt drops the global enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Out of reset, take_o is 0, vector_o is 0, nonvec_o is 0 and ack_n_o is 1. The global enable is off. All three mask bits are set, so they block.
- R2: A pending non-maskable request is accepted whether or not the global enable is on or any mask is set. It beats every other source, and its vector is 0x0024.
- R3: The non-maskable request becomes pending only in the cycle after a rising edge on nmi_req, and it is accepted only if nmi_req is still high at the query. A request held high is served once. A request that drops before the query is discarded.
- R4: The maskable sources rank high, then middle, then low, then general. At most one source wins each query.
- R5: The vectors are 0x003C for the high source, 0x0034 for the middle source and 0x002C for the low source.
- R6: A general-request win gives take_o=1, nonvec_o=1 and vector_o=0, with ack_n_o low for that one cycle only.
- R7: Maskable sources are ignored while the global enable is off. An en_pulse takes effect from the next cycle. If en_pulse and dis_pulse arrive in the same cycle, the disable wins.
- R8: Accepting any interrupt clears the global enable. This also holds when an en_pulse arrives in the same cycle.
- R9: mask_wr loads mask_in from the next cycle, with bit 2 for the high source, bit 1 for the middle source and bit 0 for the low source; a 1 blocks that source. The general request has no mask bit. A masked high-source capture stays pending and is served after it is unmasked.
- R10: A rising edge on hi_req that lasts one cycle is latched and served at a later query, and the latch clears when it is served. A middle or low request that drops before the query is not served.
- R11: take_o is high only in the cycle after a query, and only for one cycle per query. Without a query nothing is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request, edge detected and level qualified |
| hi_req | input | 1 | High maskable vectored request, captured on its rising edge |
| mid_req | input | 1 | Middle maskable vectored request, level sensitive |
| lo_req | input | 1 | Low maskable vectored request, level sensitive |
| gen_req | input | 1 | General maskable non-vectored request, level sensitive |
| en_pulse | input | 1 | Turns the global enable on |
| dis_pulse | input | 1 | Turns the global enable off |
| mask_wr | input | 1 | Loads mask_in into the mask bits |
| mask_in | input | 3 | Mask values: bit 2 high, bit 1 middle, bit 0 low |
| query | input | 1 | Instruction-boundary strobe that asks for a decision |
| take_o | output | 1 | An interrupt was accepted on the last query |
| vector_o | output | 16 | Service address of the winner, 0 when no winner or non-vectored |
| nonvec_o | output | 1 | The winner is the general non-vectored request |
| ack_n_o | output | 1 | Active-low acknowledge to the general requester |

## Verification
The hardest situations to reach are the ones where the state left by earlier cycles decides the answer. Examples are a high-source capture that was masked at its query and is served only after unmasking, and a non-maskable line that is still high but must not fire again. The stimulus reaches these by pulsing hi_req while its mask bit is set. It then rewrites the mask and pulses the enable together, and queries with no level request present. For the non-maskable line, it holds nmi_req high across three back-to-back queries. It also raises the non-maskable line and the high source in the same cycle as all the level requests, to check the order in which they are served.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NSRC     = 5;
    localparam int NMASK    = 3;
    localparam int VEC_W    = 16;

    // Rank order: index 0 wins over every higher index.
    localparam int IDX_NMI  = 0;
    localparam int IDX_HI   = 1;
    localparam int IDX_MID  = 2;
    localparam int IDX_LO   = 3;
    localparam int IDX_GEN  = 4;

    // Mask bit positions
    localparam int MB_HI    = 2;
    localparam int MB_MID   = 1;
    localparam int MB_LO    = 0;

    // Vector of a ranked source: the vectored levels are spaced by a fixed
    // step above the non-maskable base; the general request has none.
    function automatic logic [VEC_W-1:0] vec_of(input int idx,
                                                input logic [VEC_W-1:0] base,
                                                input logic [VEC_W-1:0] step);
        logic [VEC_W-1:0] v;
        v = '0;
        if (idx == IDX_NMI)
            v = base;
        else if (idx < IDX_GEN)
            v = base + step * VEC_W'(IDX_GEN - idx);
        return v;
    endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter bit LEVEL_QUAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    output logic elig
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise;

    assign rise = req & ~st_q.prev;

    generate
        if (LEVEL_QUAL) begin : g_level
            always_comb begin
                st_d      = st_q;
                st_d.prev = req;
                st_d.pend = (st_q.pend | rise) & req & ~clr;
            end
            assign elig = st_q.pend & req;
        end else begin : g_sticky
            always_comb begin
                st_d      = st_q;
                st_d.prev = req;
                st_d.pend = (st_q.pend & ~clr) | rise;
            end
            assign elig = st_q.pend;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A pending flag only appears right after a low-to-high request edge
    assert_pend_from_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> ($past(req) && !$past(st_q.prev)));

    // Clearing a serviced request removes it from the next decision
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !st_q.pend);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_rank
            assign grant[i]   = elig[i] & ~taken[i];
            assign taken[i+1] = taken[i] | elig[i];
        end
    endgenerate

    assign any = taken[N];

    always_comb begin
        assert_single_winner_R4: assert ($onehot0(grant));
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int               VW       = VEC_W,
    parameter logic [VW-1:0]    VEC_BASE = 16'h0024,
    parameter logic [VW-1:0]    VEC_STEP = 16'h0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic              hi_req,
    input  logic              mid_req,
    input  logic              lo_req,
    input  logic              gen_req,
    input  logic              en_pulse,
    input  logic              dis_pulse,
    input  logic              mask_wr,
    input  logic [NMASK-1:0]  mask_in,
    input  logic              query,
    output logic              take_o,
    output logic [VW-1:0]     vector_o,
    output logic              nonvec_o,
    output logic              ack_n_o
);
    typedef struct packed {
        logic             ie;
        logic [NMASK-1:0] mask;
        logic             take;
        logic [VW-1:0]    vec;
        logic             nonvec;
    } ctl_t;

    ctl_t            c_d, c_q;
    logic            nmi_elig, hi_pend;
    logic [NSRC-1:0] elig, grant;
    logic            any, accept;
    logic [VW-1:0]   win_vec;

    irq_edge_latch #(.LEVEL_QUAL(1'b1)) u_nmi_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (nmi_req),
        .clr  (query & grant[IDX_NMI]),
        .elig (nmi_elig)
    );

    irq_edge_latch #(.LEVEL_QUAL(1'b0)) u_hi_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (hi_req),
        .clr  (query & grant[IDX_HI]),
        .elig (hi_pend)
    );

    always_comb begin
        elig          = '0;
        elig[IDX_NMI] = nmi_elig;
        elig[IDX_HI]  = hi_pend & ~c_q.mask[MB_HI]  & c_q.ie;
        elig[IDX_MID] = mid_req & ~c_q.mask[MB_MID] & c_q.ie;
        elig[IDX_LO]  = lo_req  & ~c_q.mask[MB_LO]  & c_q.ie;
        elig[IDX_GEN] = gen_req & c_q.ie;
    end

    irq_prio_pick #(.N(NSRC)) u_pick (
        .elig (elig),
        .grant(grant),
        .any  (any)
    );

    always_comb begin
        win_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) win_vec = vec_of(i, VEC_BASE, VEC_STEP);
        end
    end

    assign accept = query & any;

    always_comb begin
        c_d = c_q;
        if (accept || dis_pulse) c_d.ie = 1'b0;
        else if (en_pulse)       c_d.ie = 1'b1;
        if (mask_wr) c_d.mask = mask_in;
        c_d.take   = accept;
        c_d.vec    = accept ? win_vec : '0;
        c_d.nonvec = accept & grant[IDX_GEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.mask <= '1;
        end else begin
            c_q      <= c_d;
        end
    end

    assign take_o   = c_q.take;
    assign vector_o = c_q.vec;
    assign nonvec_o = c_q.nonvec;
    assign ack_n_o  = ~(c_q.take & c_q.nonvec);

    assert_take_needs_query_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(query));

    assert_ack_only_nonvec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_o |-> (take_o && nonvec_o && vector_o == '0));

    assert_ie_dropped_on_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !c_q.ie);

    assert_maskable_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o != VEC_BASE) |-> $past(c_q.ie));

    assert_nmi_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o == VEC_BASE) |-> $past(nmi_req));

    assert_known_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !nonvec_o) |-> (vector_o == VEC_BASE
                                || vector_o == VEC_BASE + VEC_STEP
                                || vector_o == VEC_BASE + 2 * VEC_STEP
                                || vector_o == VEC_BASE + 3 * VEC_STEP));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 0, hi_req = 0, mid_req = 0, lo_req = 0, gen_req = 0;
    logic        en_pulse = 0, dis_pulse = 0, mask_wr = 0, query = 0;
    logic [2:0]  mask_in = '0;
    logic        take_o, nonvec_o, ack_n_o;
    logic [15:0] vector_o;

    typedef struct packed {
        logic        take;
        logic [15:0] vec;
        logic        nv;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_bad = 0;
    bit    done = 0;

    always #10 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .nmi_req(nmi_req), .hi_req(hi_req), .mid_req(mid_req),
        .lo_req(lo_req), .gen_req(gen_req),
        .en_pulse(en_pulse), .dis_pulse(dis_pulse),
        .mask_wr(mask_wr), .mask_in(mask_in), .query(query),
        .take_o(take_o), .vector_o(vector_o), .nonvec_o(nonvec_o),
        .ack_n_o(ack_n_o)
    );

    // r = {nmi, hi, mid, lo, gen}
    task automatic cyc(input logic [4:0] r, input logic en, input logic dis,
                       input logic mw, input logic [2:0] m, input logic q,
                       input logic et, input logic [15:0] ev, input logic env,
                       input string tag);
        @(negedge clk);
        {nmi_req, hi_req, mid_req, lo_req, gen_req} = r;
        en_pulse = en; dis_pulse = dis; mask_wr = mw; mask_in = m; query = q;
        exp_q.push_back('{take: et, vec: ev, nv: env});
        tag_q.push_back(tag);
    endtask

    // Monitor: one expected item per driven cycle, sampled 5 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (take_o !== e.take || vector_o !== e.vec || nonvec_o !== e.nv
                    || ack_n_o !== !(e.take && e.nv)) begin
                    n_bad++;
                    $display("FAIL %s: take=%0b vec=%h nv=%0b ack_n=%0b, expected take=%0b vec=%h nv=%0b ack_n=%0b",
                             t, take_o, vector_o, nonvec_o, ack_n_o,
                             e.take, e.vec, e.nv, !(e.take && e.nv));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (take_o !== 1'b0 || vector_o !== 16'h0 || nonvec_o !== 1'b0 || ack_n_o !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 reset: take=%0b vec=%h nv=%0b ack_n=%0b, expected 0 0000 0 1",
                     take_o, vector_o, nonvec_o, ack_n_o);
        end
        rst_n = 1'b1;

        cyc(5'b00111, 0,0,0,3'b000, 1, 0,16'h0000,0, "R7 enable off at reset");
        cyc(5'b00000, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable pulse");
        cyc(5'b00010, 0,0,0,3'b000, 1, 0,16'h0000,0, "R1 masks set at reset");
        cyc(5'b00001, 0,0,0,3'b000, 1, 1,16'h0000,1, "R6 general request");
        cyc(5'b00000, 0,0,1,3'b000, 0, 0,16'h0000,0, "R9 unmask all");
        cyc(5'b00000, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable");
        cyc(5'b00111, 0,0,0,3'b000, 1, 1,16'h0034,0, "R4 middle over low and general");
        cyc(5'b00111, 0,0,0,3'b000, 1, 0,16'h0000,0, "R8 enable cleared after take");
        cyc(5'b00000, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable");
        cyc(5'b00011, 0,0,0,3'b000, 1, 1,16'h002C,0, "R4 low over general");
        cyc(5'b00000, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable");
        cyc(5'b00001, 0,0,0,3'b000, 1, 1,16'h0000,1, "R6 general alone");

        cyc(5'b01000, 0,0,0,3'b000, 0, 0,16'h0000,0, "R10 high pulse");
        cyc(5'b00000, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable");
        cyc(5'b00100, 0,0,0,3'b000, 1, 1,16'h003C,0, "R10 latched high over middle");
        cyc(5'b00000, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable");
        cyc(5'b00100, 0,0,0,3'b000, 1, 1,16'h0034,0, "R10 high latch cleared");
        cyc(5'b00000, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable");
        cyc(5'b00100, 0,0,0,3'b000, 0, 0,16'h0000,0, "R11 no query");
        cyc(5'b00000, 0,0,0,3'b000, 1, 0,16'h0000,0, "R10 dropped level not served");

        cyc(5'b00000, 0,0,1,3'b100, 0, 0,16'h0000,0, "R9 mask high");
        cyc(5'b01000, 0,0,0,3'b000, 0, 0,16'h0000,0, "R9 high pulse while masked");
        cyc(5'b00010, 0,0,0,3'b000, 1, 1,16'h002C,0, "R9 masked high skipped");
        cyc(5'b00000, 1,0,1,3'b000, 0, 0,16'h0000,0, "R9 unmask and enable");
        cyc(5'b00000, 0,0,0,3'b000, 1, 1,16'h003C,0, "R9 pending high served after unmask");
        cyc(5'b00000, 1,0,1,3'b001, 0, 0,16'h0000,0, "R9 mask low and enable");
        cyc(5'b00011, 0,0,0,3'b000, 1, 1,16'h0000,1, "R9 general has no mask");

        cyc(5'b10000, 0,0,0,3'b000, 1, 0,16'h0000,0, "R3 edge not yet pending");
        cyc(5'b10000, 0,0,0,3'b000, 1, 1,16'h0024,0, "R2 trap with enable off");
        cyc(5'b10000, 0,0,0,3'b000, 1, 0,16'h0000,0, "R3 held high no retrigger");
        cyc(5'b00000, 0,0,0,3'b000, 0, 0,16'h0000,0, "R3 release");
        cyc(5'b10000, 0,0,0,3'b000, 0, 0,16'h0000,0, "R3 short pulse");
        cyc(5'b00000, 0,0,0,3'b000, 1, 0,16'h0000,0, "R3 dropped before query");

        cyc(5'b11111, 1,0,1,3'b000, 0, 0,16'h0000,0, "R2 all sources rise");
        cyc(5'b10111, 0,0,0,3'b000, 1, 1,16'h0024,0, "R2 trap beats all");
        cyc(5'b10111, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable");
        cyc(5'b10111, 0,0,0,3'b000, 1, 1,16'h003C,0, "R4 high after trap");

        cyc(5'b00111, 1,1,0,3'b000, 0, 0,16'h0000,0, "R7 enable and disable together");
        cyc(5'b00111, 0,0,0,3'b000, 1, 0,16'h0000,0, "R7 disable wins");
        cyc(5'b00010, 1,0,0,3'b000, 1, 0,16'h0000,0, "R7 enable not effective same cycle");
        cyc(5'b00010, 1,0,0,3'b000, 1, 1,16'h002C,0, "R8 take with enable pulse");
        cyc(5'b00010, 0,0,0,3'b000, 1, 0,16'h0000,0, "R8 take beats enable pulse");

        cyc(5'b00000, 1,0,0,3'b000, 0, 0,16'h0000,0, "R7 enable");
        cyc(5'b00111, 0,0,0,3'b000, 0, 0,16'h0000,0, "R11 levels without query");
        cyc(5'b00111, 0,0,0,3'b000, 0, 0,16'h0000,0, "R11 levels without query");
        cyc(5'b00000, 0,0,0,3'b000, 1, 0,16'h0000,0, "R11 query with nothing pending");
        cyc(5'b00001, 0,0,0,3'b000, 1, 1,16'h0000,1, "R6 general after idle");
        cyc(5'b00000, 0,0,0,3'b000, 0, 0,16'h0000,0, "R6 acknowledge lasts one cycle");
        cyc(5'b00000, 0,0,0,3'b000, 0, 0,16'h0000,0, "R11 idle");

        repeat (3) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R11 scoreboard: %0d items left, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule